// File: doc/BRIEF.md
# Local Bus Disk Port Claim and Ready Sequencer

This block sits on a processor local bus in front of an IDE-style disk port. On every clock it looks at the active-low address strobe. When the strobe is low it classifies the cycle: memory or I/O, read or write. It compares the I/O address against the two task-file channel bases, 1F0h and 170h. A cycle that matches is claimed. The block then pulls its local-device output low and takes control of the shared ready line.

The ready line is shared by every target on the bus, so it is driven only for claimed cycles. First it is driven high. It is pulled low for a single clock when the cycle completes, then driven high for one more clock, and then released. The release is signalled through a separate output-enable pin that the pad ring uses to build the tri-state buffer.

A mode pin selects between two behaviours. In enhanced mode, the drive-ready input holds off completion of data-port cycles. In legacy mode, the same pin carries a data/code status that keeps interrupt-acknowledge and halt cycles from being claimed. The block also reports the transfer direction, and it flags a 32-bit data transfer when the upper byte enable is active.

Top module: `lbus_claim_ready`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs in the following cycle are `ldev_n`=1, `lrdy_oe`=0, `xfer32`=0 and `cyc_wr`=0.
- R2: A strobe (`ads_n`=0) sampled in idle claims the cycle when all of the following hold: `mem_io`=0, `addr[15:10]`=0, and `addr[9:3]` equals 7'h3E (1F0h) or 7'h2E (170h). `ldev_n` goes low in the next cycle and stays low up to and including the cycle in which `lrdy_n` is low. Any other value of `addr[9:3]` is not claimed.
- R3: A cycle with `mem_io`=1 (memory) is never claimed: `ldev_n` and `lrdy_oe` remain inactive.
- R4: While `ldev_n` is low, `cyc_wr` equals the `wr_rd` value captured at the strobe (1 = write). At all other times `cyc_wr` is 0.
- R5: `lrdy_oe` is high only for a claimed cycle. It rises together with the fall of `ldev_n`, and `lrdy_n` is 1 in the first driven cycle.
- R6: `lrdy_n` is driven low for exactly one cycle. The next cycle is driven high, and in the cycle after that `lrdy_oe` is 0.
- R7: `ldev_n` is low with `lrdy_n` high for at least MIN_WAIT cycles (default 2). In enhanced mode (`adv_mode`=1), a data-port cycle (`addr[2:0]`=0) leaves that wait only at an edge where `drv_rdy` is 1.
- R8: While `ldev_n` is low, `xfer32` equals the inverse of `be_upper_n` captured at the strobe. At all other times `xfer32` is 0.
- R9: In legacy mode (`adv_mode`=0), a strobe is claimed only if `drv_rdy`=1 at the strobe. `drv_rdy` never delays completion, so the wait is exactly MIN_WAIT cycles.
- R10: A strobe that arrives while a claimed cycle is in progress, from the claim up to the release of `lrdy_oe`, is ignored. It starts no new claim and does not change `cyc_wr` or `xfer32`.
- R11: All eight register offsets (`addr[2:0]` 0 to 7) of both channels are claimed. Offsets other than 0 complete after exactly MIN_WAIT wait cycles, whatever the level of `drv_rdy`.
- R12: A strobe with any of `addr[15:10]` non-zero is not claimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high system reset |
| ads_n | input | 1 | Address strobe, active low |
| mem_io | input | 1 | Cycle space: 1 = memory, 0 = I/O |
| wr_rd | input | 1 | Cycle direction: 1 = write, 0 = read |
| be_upper_n | input | 1 | Upper byte enable (byte 2), active low |
| addr | input | ADDR_W | I/O address |
| adv_mode | input | 1 | 1 = enhanced mode, 0 = legacy mode |
| drv_rdy | input | 1 | Drive ready (enhanced mode) or data/code status (legacy mode) |
| ldev_n | output | 1 | Local-device claim, active low |
| lrdy_n | output | 1 | Ready value, active low; meaningful only while lrdy_oe=1 |
| lrdy_oe | output | 1 | Drive enable for the shared ready line |
| xfer32 | output | 1 | 32-bit data transfer flag for the claimed cycle |
| cyc_wr | output | 1 | Direction of the claimed cycle, 1 = write |

## Verification
The sequencer phase is fully visible at the ports. A wrong phase shows up in the very next cycle as a mismatch in `ldev_n`, `lrdy_oe` or `lrdy_n` against the bench's own phase model. A corrupted captured attribute appears on `cyc_wr` or `xfer32` during the first claimed cycle. A broken wait counter or throttle shows up at the cycle of the ready pulse, which then comes early or late by at least one clock. A strobe wrongly accepted while busy shows up as an extra fall of `ldev_n`, or as a change of the captured flags in the middle of the cycle.

// File: rtl/lbus_pkg.sv
package lbus_pkg;

    // phase of the claimed-cycle sequencer
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WAIT = 2'd1,
        PH_DONE = 2'd2,
        PH_TAIL = 2'd3
    } phase_t;

    // attributes captured at the strobe
    typedef struct packed {
        logic claim;
        logic data_port;
        logic write;
        logic wide;
    } cyc_info_t;

    // task-file block numbers (address bits 9:3)
    localparam logic [6:0] PRI_BLOCK = 7'h3E;
    localparam logic [6:0] SEC_BLOCK = 7'h2E;

    function automatic logic block_hit(input logic [6:0] blk);
        return (blk == PRI_BLOCK) || (blk == SEC_BLOCK);
    endfunction

endpackage

// File: rtl/lbus_cycle_decode.sv
module lbus_cycle_decode
    import lbus_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              mem_io,
    input  logic              wr_rd,
    input  logic              be_upper_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              adv_mode,
    input  logic              dc_stat,
    output cyc_info_t         info
);
    localparam int HI_W = ADDR_W - 10;

    logic hi_zero;
    logic io_ok;

    assign hi_zero = (addr[ADDR_W-1:10] == {HI_W{1'b0}});
    // legacy mode: data/code status must mark a plain I/O access
    assign io_ok   = !mem_io && (adv_mode || dc_stat);

    always_comb begin
        info.claim     = io_ok && hi_zero && block_hit(addr[9:3]);
        info.data_port = (addr[2:0] == 3'd0);
        info.write     = wr_rd;
        info.wide      = !be_upper_n;
    end
endmodule

// File: rtl/lbus_ready_seq.sv
module lbus_ready_seq
    import lbus_pkg::*;
#(
    parameter int MIN_WAIT = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      strobe,
    input  cyc_info_t info,
    input  logic      adv_mode,
    input  logic      drv_rdy,
    output logic      ldev_n,
    output logic      lrdy_n,
    output logic      lrdy_oe,
    output logic      xfer32,
    output logic      cyc_wr
);
    localparam int CNT_W = (MIN_WAIT < 2) ? 1 : $clog2(MIN_WAIT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(MIN_WAIT - 1);

    phase_t         phase;
    logic [CNT_W-1:0] cnt;
    cyc_info_t      cur;
    logic           hold_off;
    logic           finish;
    logic           claimed;

    assign hold_off = adv_mode && cur.data_port && !drv_rdy;
    assign finish   = (cnt >= LAST) && !hold_off;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            cur   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (strobe && info.claim) begin
                        phase <= PH_WAIT;
                        cnt   <= '0;
                        cur   <= info;
                    end
                end
                PH_WAIT: begin
                    if (finish)
                        phase <= PH_DONE;
                    else if (cnt < LAST)
                        cnt <= cnt + 1'b1;
                end
                PH_DONE: phase <= PH_TAIL;
                PH_TAIL: phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign claimed = (phase == PH_WAIT) || (phase == PH_DONE);
    assign ldev_n  = !claimed;
    assign lrdy_oe = (phase != PH_IDLE);
    assign lrdy_n  = (phase != PH_DONE);
    assign xfer32  = claimed && cur.wide;
    assign cyc_wr  = claimed && cur.write;

    // R6
    ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (lrdy_oe && !lrdy_n) |=> (lrdy_oe && lrdy_n));
    // R6
    ready_release_chk: assert property (@(posedge clk) disable iff (rst)
        (lrdy_oe && !lrdy_n) |=> ##1 !lrdy_oe);
    // R5
    drive_high_first_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(lrdy_oe) |-> (lrdy_n && !ldev_n));
    // R2
    claim_drives_chk: assert property (@(posedge clk) disable iff (rst)
        !ldev_n |-> lrdy_oe);
    // R7
    throttle_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WAIT && hold_off) |=> (phase == PH_WAIT));
    // R10
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE) |=> $stable(cur));
endmodule

// File: rtl/lbus_claim_ready.sv
module lbus_claim_ready
    import lbus_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int MIN_WAIT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ads_n,
    input  logic              mem_io,
    input  logic              wr_rd,
    input  logic              be_upper_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              adv_mode,
    input  logic              drv_rdy,
    output logic              ldev_n,
    output logic              lrdy_n,
    output logic              lrdy_oe,
    output logic              xfer32,
    output logic              cyc_wr
);
    cyc_info_t info;

    lbus_cycle_decode #(.ADDR_W(ADDR_W)) u_dec (
        .mem_io     (mem_io),
        .wr_rd      (wr_rd),
        .be_upper_n (be_upper_n),
        .addr       (addr),
        .adv_mode   (adv_mode),
        .dc_stat    (drv_rdy),
        .info       (info)
    );

    lbus_ready_seq #(.MIN_WAIT(MIN_WAIT)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .strobe   (!ads_n),
        .info     (info),
        .adv_mode (adv_mode),
        .drv_rdy  (drv_rdy),
        .ldev_n   (ldev_n),
        .lrdy_n   (lrdy_n),
        .lrdy_oe  (lrdy_oe),
        .xfer32   (xfer32),
        .cyc_wr   (cyc_wr)
    );
endmodule

// File: tb/sim_lbus_claim_ready.sv
`timescale 1ns/1ps
module sim_lbus_claim_ready;
    localparam int MINW = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ads_n = 1'b1, mem_io = 1'b0, wr_rd = 1'b0, be_upper_n = 1'b1;
    logic [15:0] addr = 16'h0;
    logic adv_mode = 1'b1, drv_rdy = 1'b1;
    logic ldev_n, lrdy_n, lrdy_oe, xfer32, cyc_wr;

    int tests = 0, fails = 0;
    int claims = 0;
    int wait_len = 0, last_lat = 0;
    int low_while_hold = 0;
    logic prev_ldev = 1'b1;
    bit finished = 0;

    always #10 clk = ~clk;

    lbus_claim_ready #(.ADDR_W(16), .MIN_WAIT(MINW)) u0 (
        .clk(clk), .rst(rst), .ads_n(ads_n), .mem_io(mem_io), .wr_rd(wr_rd),
        .be_upper_n(be_upper_n), .addr(addr), .adv_mode(adv_mode),
        .drv_rdy(drv_rdy), .ldev_n(ldev_n), .lrdy_n(lrdy_n),
        .lrdy_oe(lrdy_oe), .xfer32(xfer32), .cyc_wr(cyc_wr)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // behavioural reference: 0 idle, 1 waiting, 2 ready low, 3 trailing high
    int m_ph = 0, m_waited = 0;
    bit m_data = 0, m_wr = 0, m_wide = 0;

    function automatic bit would_claim();
        bit blk;
        blk = (addr[9:3] == 7'h3E) || (addr[9:3] == 7'h2E);
        return !ads_n && !mem_io && (addr[15:10] == 6'd0) && blk && (adv_mode || drv_rdy);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_ph <= 0;
        end else begin
            case (m_ph)
                0: if (would_claim()) begin
                       m_ph <= 1; m_waited <= 1;
                       m_data <= (addr[2:0] == 3'd0);
                       m_wr <= wr_rd; m_wide <= !be_upper_n;
                   end
                1: if (m_waited >= MINW && !(adv_mode && m_data && !drv_rdy)) m_ph <= 2;
                   else m_waited <= m_waited + 1;
                2: m_ph <= 3;
                default: m_ph <= 0;
            endcase
        end
    end

    always @(negedge clk) begin
        bit e_claim;
        string t;
        e_claim = (m_ph == 1) || (m_ph == 2);
        t = rst ? "R1" : "R2";
        check(ldev_n == !e_claim, t, ldev_n, !e_claim);
        t = rst ? "R1" : "R5";
        check(lrdy_oe == (m_ph != 0), t, lrdy_oe, m_ph != 0);
        if (m_ph != 0) check(lrdy_n == (m_ph != 2), "R6", lrdy_n, m_ph != 2);
        t = rst ? "R1" : "R8";
        check(xfer32 == (e_claim && m_wide), t, xfer32, e_claim && m_wide);
        t = rst ? "R1" : "R4";
        check(cyc_wr == (e_claim && m_wr), t, cyc_wr, e_claim && m_wr);
        if (prev_ldev && !ldev_n) begin claims++; wait_len = 0; end
        if (!ldev_n && lrdy_n) wait_len++;
        if (!ldev_n && !lrdy_n) last_lat = wait_len;
        if (lrdy_oe && !lrdy_n && adv_mode && !drv_rdy && addr[2:0] == 3'd0) low_while_hold++;
        prev_ldev = ldev_n;
    end

    task automatic bus(input bit mio, input bit wr, input bit be_n, input logic [15:0] a);
        @(negedge clk);
        ads_n = 1'b0; mem_io = mio; wr_rd = wr; be_upper_n = be_n; addr = a;
        @(negedge clk);
        ads_n = 1'b1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int c0;
        idle(3);
        check(ldev_n == 1 && lrdy_oe == 0, "R1", {ldev_n, lrdy_oe}, 2);
        rst = 1'b0;
        idle(2);

        c0 = claims; bus(0, 0, 0, 16'h01F0); idle(6);
        check(claims == c0 + 1, "R2", claims - c0, 1);
        check(last_lat == MINW, "R7", last_lat, MINW);

        c0 = claims; bus(0, 1, 1, 16'h0170); idle(6);
        check(claims == c0 + 1, "R4", claims - c0, 1);

        c0 = claims; bus(1, 0, 0, 16'h01F0); idle(6);
        check(claims == c0, "R3", claims - c0, 0);

        c0 = claims; bus(0, 0, 0, 16'h05F0); idle(6);
        check(claims == c0, "R12", claims - c0, 0);

        c0 = claims; bus(0, 0, 0, 16'h01F8); idle(6);
        check(claims == c0, "R2", claims - c0, 0);

        c0 = claims;
        for (int i = 0; i < 8; i++) begin
            bus(0, i[0], i[1], 16'h01F0 + 16'(i)); idle(6);
            bus(0, i[1], i[0], 16'h0170 + 16'(i)); idle(6);
        end
        check(claims == c0 + 16, "R11", claims - c0, 16);

        drv_rdy = 1'b0;
        c0 = claims; bus(0, 1, 0, 16'h01F3); idle(6);
        check(claims == c0 + 1 && last_lat == MINW, "R11", last_lat, MINW);

        bus(0, 0, 0, 16'h01F0); idle(6);
        drv_rdy = 1'b1; idle(6);
        check(low_while_hold == 0, "R7", low_while_hold, 0);
        check(last_lat > MINW, "R7", last_lat, MINW + 1);

        adv_mode = 1'b0; drv_rdy = 1'b0;
        c0 = claims; bus(0, 0, 0, 16'h01F0); idle(6);
        check(claims == c0, "R9", claims - c0, 0);
        drv_rdy = 1'b1;
        c0 = claims; bus(0, 0, 0, 16'h01F0); drv_rdy = 1'b0; idle(6);
        check(claims == c0 + 1 && last_lat == MINW, "R9", last_lat, MINW);
        drv_rdy = 1'b1; adv_mode = 1'b1;

        c0 = claims;
        @(negedge clk);
        ads_n = 0; mem_io = 0; wr_rd = 0; be_upper_n = 1; addr = 16'h01F0;
        @(negedge clk);
        wr_rd = 1; be_upper_n = 0;
        idle(3);
        ads_n = 1; idle(6);
        check(claims == c0 + 1, "R10", claims - c0, 1);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule